// File: doc/BRIEF.md
# Scratchpad Lock Table

This block sits beside a word-addressed scratchpad and gives a set of requesters atomic read-modify-write on its words. The atomicity depends on software retry. A requester first issues a lock-load. The lock-load reads a word and tries to take the lock that guards the word. The requester then changes the value in its own datapath. Finally it issues a store-conditional-unlock, which writes the word back and frees the lock. Each request returns a one-bit predicate one cycle later. The block never stalls a request. A requester that sees a false predicate simply issues its lock-load again.

The locks form a small fixed pool. The pool is indexed by byte-address bits 9 down to 2, so distinct words can alias to one lock. Each lock entry is a two-state machine with the states FREE and HELD, and it records the ID of the requester that holds it. The transitions are as follows:
- ACQUIRE (FREE to HELD) takes the lock for the winning lock-load.
- KEEP stays in HELD while no valid release arrives.
- RELEASE (HELD to FREE) frees the lock on the holder's store when no lock-load is waiting.
- HANDOFF (HELD to HELD with a new owner) applies a release and re-grants the lock in the same cycle.
- IDLE stays in FREE when nothing asks for the lock.

Top module: `sml_lock_table`

## Requirements
- R1: Every request on `req_valid[r]` produces `rsp_valid[r]` exactly one cycle later. A lock-load returns the addressed word on `rsp_rdata` in that cycle, whether or not it obtained the lock. `rsp_ok` is never high without `rsp_valid`.
- R2: The lock for an access is chosen by byte-address bits 9:2. Two addresses that agree in those bits share one lock, even when they name different words.
- R3: A lock-load to a lock held by another requester returns `rsp_ok`=0 at once. The lock and its owner stay unchanged.
- R4: A store-conditional-unlock from the holder of the lock writes `req_wdata` to the addressed word, frees the lock and returns `rsp_ok`=1.
- R5: A store-conditional-unlock from a requester that does not hold the lock, or to a free lock, returns `rsp_ok`=0. It changes neither the memory word nor the lock.
- R6: A lock-load by the current holder succeeds again and leaves the lock held by that requester.
- R7: When several requesters lock-load addresses that map to one free lock in the same cycle, only the lowest requester ID gets `rsp_ok`=1.
- R8: Requests to different lock indices in the same cycle are handled independently of each other.
- R9: A release and a lock-load to the same lock in one cycle apply the release first. The lock can therefore be re-granted in that cycle, and the lock-load returns the word as just stored.
- R10: A synchronous reset frees every lock and clears `rsp_valid` and `rsp_ok`.
- R11: The `req_op` encoding is 0 for a lock-load and 1 for a store-conditional-unlock. Requester r uses bits `[r*ADDR_W +: ADDR_W]` of `req_addr`, and the matching slices of `req_wdata` and `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_REQ | Request strobe per requester |
| req_op | input | NUM_REQ | 0 = lock-load, 1 = store-conditional-unlock |
| req_addr | input | NUM_REQ*ADDR_W | Byte address per requester |
| req_wdata | input | NUM_REQ*DATA_W | Store data per requester |
| rsp_valid | output | NUM_REQ | Response strobe, one cycle after the request |
| rsp_ok | output | NUM_REQ | Success predicate |
| rsp_rdata | output | NUM_REQ*DATA_W | Lock-load read data (zero for stores) |

## Verification
The bench builds the block with three requesters and 512 words. With 512 words, bytes 0x010 and 0x410 land on different words that share one lock, so aliasing (R2) can be observed at the ports. An odd requester count also exercises the owner field when NUM_REQ is not a power of two. Three requesters allow three-way contention for a single lock, a release that hands the lock straight to a waiting loader, and fully independent traffic to separate locks.

// File: rtl/sml_pkg.sv
package sml_pkg;

    typedef enum logic {
        OP_LOCK_LOAD    = 1'b0,
        OP_STORE_UNLOCK = 1'b1
    } sml_op_e;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lk_state_e;

endpackage

// File: rtl/sml_lock_entry.sv
module sml_lock_entry
    import sml_pkg::*;
#(
    parameter int NUM_REQ = 4,
    localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] ld_hit,
    input  logic [NUM_REQ-1:0] st_hit,
    output logic [NUM_REQ-1:0] ld_grant,
    output logic [NUM_REQ-1:0] st_accept
);

    lk_state_e        state_q, state_d;
    logic [ID_W-1:0]  owner_q, owner_d;
    logic             released;
    logic             free_now;
    logic             any_ld;
    logic [ID_W-1:0]  winner;

    // Release decision: only the recorded holder may release a held lock.
    always_comb begin
        st_accept = '0;
        released  = 1'b0;
        if (state_q == LK_HELD && st_hit[owner_q]) begin
            st_accept[owner_q] = 1'b1;
            released           = 1'b1;
        end
    end

    // Lowest requester ID among the lock-loads aimed at this entry.
    always_comb begin
        any_ld = 1'b0;
        winner = '0;
        for (int r = NUM_REQ - 1; r >= 0; r--) begin
            if (ld_hit[r]) begin
                any_ld = 1'b1;
                winner = ID_W'(r);
            end
        end
    end

    assign free_now = (state_q == LK_FREE) || released;

    // Grant outputs: a free (or just released) lock goes to the winner,
    // a held lock can only be re-confirmed by its owner.
    always_comb begin
        ld_grant = '0;
        if (free_now) begin
            if (any_ld) ld_grant[winner] = 1'b1;
        end else if (ld_hit[owner_q]) begin
            ld_grant[owner_q] = 1'b1;
        end
    end

    // Next-state logic with named transitions.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            LK_FREE: begin
                if (any_ld) begin            // ACQUIRE
                    state_d = LK_HELD;
                    owner_d = winner;
                end                          // else IDLE
            end
            LK_HELD: begin
                if (released) begin
                    if (any_ld) begin        // HANDOFF
                        state_d = LK_HELD;
                        owner_d = winner;
                    end else begin           // RELEASE
                        state_d = LK_FREE;
                    end
                end                          // else KEEP
            end
            default: state_d = LK_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

endmodule

// File: rtl/sml_scratch.sv
module sml_scratch #(
    parameter int NUM_REQ   = 4,
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 1024,
    localparam int WORD_W = $clog2(MEM_WORDS)
) (
    input  logic                      clk,
    input  logic [NUM_REQ-1:0]        wr_en,
    input  logic [NUM_REQ*WORD_W-1:0] wr_word,
    input  logic [NUM_REQ*DATA_W-1:0] wr_data,
    input  logic [NUM_REQ*WORD_W-1:0] rd_word,
    output logic [NUM_REQ*DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [MEM_WORDS];

    always_ff @(posedge clk) begin
        for (int w = 0; w < NUM_REQ; w++) begin
            if (wr_en[w]) mem[wr_word[w*WORD_W +: WORD_W]] <= wr_data[w*DATA_W +: DATA_W];
        end
    end

    // Reads see stores accepted in the same cycle (release-before-grant).
    always_comb begin
        for (int r = 0; r < NUM_REQ; r++) begin
            rd_data[r*DATA_W +: DATA_W] = mem[rd_word[r*WORD_W +: WORD_W]];
            for (int w = 0; w < NUM_REQ; w++) begin
                if (wr_en[w] && wr_word[w*WORD_W +: WORD_W] == rd_word[r*WORD_W +: WORD_W])
                    rd_data[r*DATA_W +: DATA_W] = wr_data[w*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/sml_lock_table.sv
module sml_lock_table
    import sml_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 1024,
    parameter int LOCK_W    = 8,
    localparam int WORD_W = $clog2(MEM_WORDS),
    localparam int ADDR_W = WORD_W + 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ-1:0]        req_op,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
    output logic [NUM_REQ-1:0]        rsp_valid,
    output logic [NUM_REQ-1:0]        rsp_ok,
    output logic [NUM_REQ*DATA_W-1:0] rsp_rdata
);

    localparam int LOCKS = 1 << LOCK_W;

    logic [LOCK_W-1:0]         lk_idx [NUM_REQ];
    logic [NUM_REQ*WORD_W-1:0] word_flat;
    logic [NUM_REQ-1:0]        grant_m [LOCKS];
    logic [NUM_REQ-1:0]        accept_m [LOCKS];
    logic [NUM_REQ-1:0]        ok_d;
    logic [NUM_REQ-1:0]        wr_en;
    logic [NUM_REQ*DATA_W-1:0] rd_data;

    always_comb begin
        for (int r = 0; r < NUM_REQ; r++) begin
            lk_idx[r] = req_addr[r*ADDR_W + 2 +: LOCK_W];
            word_flat[r*WORD_W +: WORD_W] = req_addr[r*ADDR_W + 2 +: WORD_W];
        end
    end

    for (genvar l = 0; l < LOCKS; l++) begin : g_lock
        logic [NUM_REQ-1:0] ld_hit;
        logic [NUM_REQ-1:0] st_hit;
        logic [NUM_REQ-1:0] ld_grant;
        logic [NUM_REQ-1:0] st_accept;

        always_comb begin
            for (int r = 0; r < NUM_REQ; r++) begin
                ld_hit[r] = req_valid[r] && (req_op[r] == OP_LOCK_LOAD) && (lk_idx[r] == LOCK_W'(l));
                st_hit[r] = req_valid[r] && (req_op[r] == OP_STORE_UNLOCK) && (lk_idx[r] == LOCK_W'(l));
            end
        end

        sml_lock_entry #(.NUM_REQ(NUM_REQ)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .ld_hit    (ld_hit),
            .st_hit    (st_hit),
            .ld_grant  (ld_grant),
            .st_accept (st_accept)
        );

        assign grant_m[l]  = ld_grant;
        assign accept_m[l] = st_accept;
    end

    always_comb begin
        for (int r = 0; r < NUM_REQ; r++) begin
            if (req_op[r] == OP_STORE_UNLOCK) begin
                ok_d[r]  = req_valid[r] && accept_m[lk_idx[r]][r];
                wr_en[r] = req_valid[r] && accept_m[lk_idx[r]][r];
            end else begin
                ok_d[r]  = req_valid[r] && grant_m[lk_idx[r]][r];
                wr_en[r] = 1'b0;
            end
        end
    end

    sml_scratch #(
        .NUM_REQ   (NUM_REQ),
        .DATA_W    (DATA_W),
        .MEM_WORDS (MEM_WORDS)
    ) u_scratch (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_word (word_flat),
        .wr_data (req_wdata),
        .rd_word (word_flat),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= '0;
            rsp_ok    <= '0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= ok_d;
            for (int r = 0; r < NUM_REQ; r++) begin
                rsp_rdata[r*DATA_W +: DATA_W] <= (req_op[r] == OP_LOCK_LOAD) ?
                                                 rd_data[r*DATA_W +: DATA_W] : '0;
            end
        end
    end

endmodule

// File: rtl/sml_lock_table_chk.sv
module sml_lock_table_chk #(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 12,
    parameter int LOCK_W  = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_REQ-1:0]        req_valid,
    input logic [NUM_REQ-1:0]        req_op,
    input logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input logic [NUM_REQ-1:0]        rsp_valid,
    input logic [NUM_REQ-1:0]        rsp_ok
);

    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    p_ok_needs_valid_r1: assert property (@(posedge clk) disable iff (rst)
        (rsp_ok & ~rsp_valid) == '0);

    p_reset_clears_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rsp_valid == '0 && rsp_ok == '0));

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_i
        for (genvar j = i + 1; j < NUM_REQ; j++) begin : g_j
            logic same_ll;
            assign same_ll = req_valid[i] && req_valid[j] && !req_op[i] && !req_op[j] &&
                             (req_addr[i*ADDR_W + 2 +: LOCK_W] == req_addr[j*ADDR_W + 2 +: LOCK_W]);

            p_single_winner_r7: assert property (@(posedge clk) disable iff (rst)
                same_ll |=> !(rsp_ok[i] && rsp_ok[j]));
        end
    end

endmodule

bind sml_lock_table sml_lock_table_chk #(
    .NUM_REQ (NUM_REQ),
    .ADDR_W  (ADDR_W),
    .LOCK_W  (LOCK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok)
);

// File: tb/sml_lock_table_bench.sv
module sml_lock_table_bench;

    localparam int NR  = 3;
    localparam int DW  = 32;
    localparam int AW  = 11;   // 512 words -> 9 word bits + 2 byte bits

    logic              clk = 1'b0;
    logic              rst;
    logic [NR-1:0]     req_valid;
    logic [NR-1:0]     req_op;
    logic [NR*AW-1:0]  req_addr;
    logic [NR*DW-1:0]  req_wdata;
    logic [NR-1:0]     rsp_valid;
    logic [NR-1:0]     rsp_ok;
    logic [NR*DW-1:0]  rsp_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sml_lock_table #(
        .NUM_REQ   (NR),
        .DATA_W    (DW),
        .MEM_WORDS (512),
        .LOCK_W    (8)
    ) u_sml_lock_table (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .rsp_rdata (rsp_rdata)
    );

    typedef struct packed {
        logic [3:0]  req;    // requirement number checked
        logic [1:0]  rid;
        logic        op;     // 0 lock-load, 1 store-conditional-unlock (R11)
        logic [10:0] addr;
        logic [31:0] wd;
        logic        ok;
        logic        chk_d;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  2'd0, 1'b0, 11'h010, 32'h0,   1'b1, 1'b0, 32'h0},   // R1 acquire
        '{4'd4,  2'd0, 1'b1, 11'h010, 32'hA5,  1'b1, 1'b0, 32'h0},   // R4 store by holder
        '{4'd1,  2'd1, 1'b0, 11'h010, 32'h0,   1'b1, 1'b1, 32'hA5},  // R1 data returned
        '{4'd3,  2'd0, 1'b0, 11'h010, 32'h0,   1'b0, 1'b1, 32'hA5},  // R3 held by other
        '{4'd5,  2'd0, 1'b1, 11'h010, 32'hBAD, 1'b0, 1'b0, 32'h0},   // R5 non-owner store
        '{4'd6,  2'd1, 1'b0, 11'h010, 32'h0,   1'b1, 1'b1, 32'hA5},  // R6 relock, R5 word kept
        '{4'd4,  2'd1, 1'b1, 11'h010, 32'h11,  1'b1, 1'b0, 32'h0},   // R4
        '{4'd5,  2'd1, 1'b1, 11'h010, 32'h22,  1'b0, 1'b0, 32'h0},   // R5 store to free lock
        '{4'd5,  2'd2, 1'b0, 11'h010, 32'h0,   1'b1, 1'b1, 32'h11},  // R5 word not overwritten
        '{4'd2,  2'd0, 1'b0, 11'h410, 32'h0,   1'b0, 1'b0, 32'h0},   // R2 alias blocked
        '{4'd8,  2'd0, 1'b0, 11'h014, 32'h0,   1'b1, 1'b0, 32'h0},   // R8 other index
        '{4'd4,  2'd0, 1'b1, 11'h014, 32'h55,  1'b1, 1'b0, 32'h0},   // R4
        '{4'd4,  2'd2, 1'b1, 11'h010, 32'h33,  1'b1, 1'b0, 32'h0},   // R4
        '{4'd2,  2'd0, 1'b0, 11'h410, 32'h0,   1'b1, 1'b0, 32'h0},   // R2 alias now free
        '{4'd4,  2'd0, 1'b1, 11'h410, 32'h77,  1'b1, 1'b0, 32'h0},   // R4
        '{4'd2,  2'd1, 1'b0, 11'h410, 32'h0,   1'b1, 1'b1, 32'h77},  // R2 separate words
        '{4'd4,  2'd1, 1'b1, 11'h410, 32'h78,  1'b1, 1'b0, 32'h0},   // R4
        '{4'd2,  2'd2, 1'b0, 11'h010, 32'h0,   1'b1, 1'b1, 32'h33},  // R2 word 4 intact
        '{4'd4,  2'd2, 1'b1, 11'h010, 32'h33,  1'b1, 1'b0, 32'h0}    // R4
    };

    task automatic idle();
        req_valid = '0;
        req_op    = '0;
        req_addr  = '0;
        req_wdata = '0;
    endtask

    task automatic set_req(int r, logic op, logic [AW-1:0] a, logic [DW-1:0] d);
        req_valid[r]          = 1'b1;
        req_op[r]             = op;
        req_addr[r*AW +: AW]  = a;
        req_wdata[r*DW +: DW] = d;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset rsp_valid", 32'(rsp_valid), 32'h0);
        check("R10 reset rsp_ok", 32'(rsp_ok), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 no request no response", 32'(rsp_valid), 32'h0);

        // Table walk: one request per step, response sampled next negedge.
        for (int v = 0; v < NV; v++) begin
            idle();
            set_req(int'(VECS[v].rid), VECS[v].op, VECS[v].addr, VECS[v].wd);
            @(negedge clk);
            check($sformatf("R%0d step %0d valid", VECS[v].req, v),
                  32'(rsp_valid), 32'(1 << VECS[v].rid));
            check($sformatf("R%0d step %0d ok", VECS[v].req, v),
                  32'(rsp_ok[VECS[v].rid]), 32'(VECS[v].ok));
            if (VECS[v].chk_d)
                check($sformatf("R%0d step %0d data", VECS[v].req, v),
                      rsp_rdata[VECS[v].rid*DW +: DW], VECS[v].rd);
        end

        // R7: three-way contention for free lock 8 (0x420 aliases 0x020, R2)
        idle();
        set_req(0, 1'b0, 11'h020, 32'h0);
        set_req(1, 1'b0, 11'h020, 32'h0);
        set_req(2, 1'b0, 11'h420, 32'h0);
        @(negedge clk);
        check("R7 contention ok vector", 32'(rsp_ok), 32'h1);

        // R9: release by r0 and loads by r1,r2 in one cycle
        idle();
        set_req(0, 1'b1, 11'h020, 32'h9);
        set_req(1, 1'b0, 11'h020, 32'h0);
        set_req(2, 1'b0, 11'h420, 32'h0);
        @(negedge clk);
        check("R9 handoff ok vector", 32'(rsp_ok), 32'h3);
        check("R9 forwarded data", rsp_rdata[1*DW +: DW], 32'h9);

        idle();
        set_req(1, 1'b1, 11'h020, 32'hA);
        @(negedge clk);
        check("R4 new owner releases", 32'(rsp_ok), 32'h2);

        // R8: independent locks in the same cycle
        idle();
        set_req(0, 1'b0, 11'h030, 32'h0);
        set_req(1, 1'b0, 11'h034, 32'h0);
        set_req(2, 1'b0, 11'h038, 32'h0);
        @(negedge clk);
        check("R8 parallel acquire", 32'(rsp_ok), 32'h7);
        idle();
        set_req(0, 1'b1, 11'h030, 32'hC0);
        set_req(1, 1'b1, 11'h034, 32'hC1);
        set_req(2, 1'b1, 11'h038, 32'hC2);
        @(negedge clk);
        check("R8 parallel release", 32'(rsp_ok), 32'h7);
        idle();
        set_req(0, 1'b0, 11'h034, 32'h0);
        set_req(1, 1'b0, 11'h038, 32'h0);
        @(negedge clk);
        check("R8 parallel data r0", rsp_rdata[0*DW +: DW], 32'hC1);
        check("R8 parallel data r1", rsp_rdata[1*DW +: DW], 32'hC2);
        idle();
        set_req(0, 1'b1, 11'h034, 32'hC1);
        set_req(1, 1'b1, 11'h038, 32'hC2);
        @(negedge clk);

        // R10: reset frees a held lock
        idle();
        set_req(2, 1'b0, 11'h040, 32'h0);
        @(negedge clk);
        check("R10 pre-reset acquire", 32'(rsp_ok), 32'h4);
        idle();
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset clears valid", 32'(rsp_valid), 32'h0);
        rst = 1'b0;
        set_req(0, 1'b0, 11'h040, 32'h0);
        @(negedge clk);
        check("R10 lock free after reset", 32'(rsp_ok), 32'h1);
        idle();
        @(negedge clk);
        check("R1 idle after request", 32'(rsp_valid), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule